// File: doc/BRIEF.md
# FSK Tag-Emulation Waveform Generator

This block turns a stream of data bits into the modulation sample stream that a low-frequency tag emulator applies to its coil. It produces one sample per field-clock tick: 1 leaves the coil open and 0 shorts it. Each data bit is shown as a run of square waves. Each wave has one of two programmable periods. The bit lasts for a programmable number of field cycles, called the bit clock.

Often the bit clock is not a whole multiple of the wave period. The block then handles the leftover cycles in one of two ways, chosen from the arithmetic of the two values. If the leftover divides the wave period, the block inserts a whole extra wave on every Nth bit. If it does not, the block adds a short partial wave to every bit. A fixed legacy mode is also provided. It emits the classic eight-cycle and ten-cycle bursts, with the ones first in each wave.

The data source replays its frame without end and marks the last bit of each frame. The block restarts its remainder bookkeeping at every frame boundary. A start pulse captures the parameters. A stop pulse returns the block to idle with the coil shorted.

Top module: `fsk_wavegen`

## Requirements
- R1: When a data bit equals `invert`, the bit uses the `fc_low` period. Any other bit value uses the `fc_high` period.
- R2: A full wave of period L is L-floor(L/2) zeros followed by floor(L/2) ones. An odd period therefore has its extra sample in the low half.
- R3: Each bit begins with floor(clock/fc) full waves of the selected period fc. The remainder is m = clock mod fc. A bit with clock < fc has no full waves before its remainder handling, and it may emit no samples at all.
- R4: A 16-bit modifier count increments on each bit with m != 0. When fc is an exact multiple of m, one extra full wave is appended whenever the incremented count is a multiple of fc/m.
- R5: When m != 0 and fc is not a multiple of m, every bit ends with a partial wave of m samples: m-floor(m/2) zeros, then floor(m/2) ones.
- R6: The modifier count restarts from zero on the first bit after start and on the bit after one marked `bit_last`. It wraps silently.
- R7: With `legacy` = 1, a bit equal to `invert` emits 11110000 six times (48 samples). Any other bit value emits 1111100000 five times (50 samples). In this mode the period and clock inputs are not used.
- R8: `mod_out` changes only on a clock edge where `tick` is high (or on stop or start). It advances by exactly one sample per tick, and consecutive frames follow without gaps.
- R9: A `stop` pulse drives `mod_out` to 0 and `busy` to 0 on the next clock edge.
- R10: Outside legacy mode, a start with `fc_high` < 2, `fc_low` < 2 or `bit_clock` = 0 sets `cfg_err` and leaves the block idle with `mod_out` at 0.
- R11: The period, clock, invert and legacy inputs are captured at start. Changing them while the block runs has no effect on the output.
- R12: After reset, `mod_out`, `busy`, `cfg_err` and `bit_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures parameters and begins streaming |
| stop | input | 1 | Returns to idle with the coil shorted |
| tick | input | 1 | Field-clock tick, one output sample each |
| legacy | input | 1 | Selects the fixed 8/10 burst mode |
| invert | input | 1 | Bit value that selects the low period |
| fc_high | input | W | Wave period for the high symbol, in ticks |
| fc_low | input | W | Wave period for the low symbol, in ticks |
| bit_clock | input | W | Bit length in ticks |
| bit_valid | input | 1 | Source has a data bit |
| bit_data | input | 1 | Data bit |
| bit_last | input | 1 | Marks the final bit of a frame |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| mod_out | output | 1 | Modulation sample: 1 open, 0 shorted |
| busy | output | 1 | Block is streaming |
| cfg_err | output | 1 | Last start had invalid parameters |

## Verification
Four behaviours are checked on every cycle by assertions:
- the output moves only on a tick, on start or on stop;
- the output is low whenever the block is idle;
- a stop leaves the block idle and shorted;
- a start with a bad period raises the error flag.

The wave shapes, the choice between an extra wave and a partial wave, the clearing of the count at each frame boundary and the legacy bursts are all about sample order. Only the bench's scenarios can show these. The bench compares whole captured sample streams against a model built from the requirements.

// File: rtl/fsk_wavegen.sv
module fsk_wavegen #(
  parameter int W  = 8,
  parameter int CW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic         tick,
  input  logic         legacy,
  input  logic         invert,
  input  logic [W-1:0] fc_high,
  input  logic [W-1:0] fc_low,
  input  logic [W-1:0] bit_clock,
  input  logic         bit_valid,
  input  logic         bit_data,
  input  logic         bit_last,
  output logic         bit_ready,
  output logic         mod_out,
  output logic         busy,
  output logic         cfg_err
);

  localparam logic [W-1:0] LEG_SHORT = W'(8);
  localparam logic [W-1:0] LEG_LONG  = W'(10);

  logic          have, first, lgc_q, inv_q;
  logic [W-1:0]  fch_q, fcl_q, clk_q;
  logic [W-1:0]  len, pos, waves, tail;
  logic [CW-1:0] modcnt;

  logic          sel_lo, md_nz, fits, extra, bad, take, last_smp, smp;
  logic [W-1:0]  fc_sel, nw, md, md_div, adj, tail_nx, waves_nx;
  logic [CW-1:0] cnt_nx;

  assign sel_lo   = (bit_data == inv_q);
  assign fc_sel   = lgc_q ? (sel_lo ? LEG_SHORT : LEG_LONG) : (sel_lo ? fcl_q : fch_q);
  assign nw       = lgc_q ? (sel_lo ? W'(6) : W'(5)) : clk_q / fc_sel;
  assign md       = lgc_q ? '0 : clk_q % fc_sel;
  assign md_nz    = (md != '0);
  assign md_div   = md_nz ? md : W'(1);
  assign fits     = ((fc_sel % md_div) == '0);
  assign adj      = fc_sel / md_div;
  assign cnt_nx   = (first ? '0 : modcnt) + CW'(md_nz);
  assign extra    = md_nz && fits && ((cnt_nx % CW'(adj)) == '0);
  assign tail_nx  = (md_nz && !fits) ? md : '0;
  assign waves_nx = nw + W'(extra);

  assign bad       = !legacy && ((fc_high < W'(2)) || (fc_low < W'(2)) || (bit_clock == '0));
  assign bit_ready = busy && !have;
  assign take      = bit_valid && bit_ready;
  assign last_smp  = (pos == len - W'(1));
  assign smp       = lgc_q ? (pos < (len >> 1)) : (pos >= len - (len >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cfg_err <= 1'b0; mod_out <= 1'b0; have <= 1'b0; first <= 1'b0;
      lgc_q <= 1'b0; inv_q <= 1'b0; fch_q <= '0; fcl_q <= '0; clk_q <= '0;
      len <= '0; pos <= '0; waves <= '0; tail <= '0; modcnt <= '0;
    end else if (stop) begin
      busy <= 1'b0; have <= 1'b0; mod_out <= 1'b0;
    end else if (start) begin
      cfg_err <= bad; busy <= !bad; have <= 1'b0; first <= 1'b1; mod_out <= 1'b0;
      lgc_q <= legacy; inv_q <= invert; fch_q <= fc_high; fcl_q <= fc_low; clk_q <= bit_clock;
    end else if (busy) begin
      if (take) begin
        modcnt <= cnt_nx;
        first  <= bit_last;
        pos    <= '0;
        if (waves_nx != '0) begin
          len <= fc_sel; waves <= waves_nx; tail <= tail_nx; have <= 1'b1;
        end else if (tail_nx != '0) begin
          len <= tail_nx; waves <= W'(1); tail <= '0; have <= 1'b1;
        end
      end
      if (tick) begin
        if (have) begin
          mod_out <= smp;
          if (last_smp) begin
            pos <= '0;
            if (waves > W'(1)) waves <= waves - W'(1);
            else if (tail != '0) begin
              len <= tail; tail <= '0;
            end else begin
              have <= 1'b0; waves <= '0;
            end
          end else begin
            pos <= pos + W'(1);
          end
        end else begin
          mod_out <= 1'b0;
        end
      end
    end
  end

  // R9
  stop_shorts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!mod_out && !busy));

  // R10
  bad_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !legacy && (fc_low < W'(2))) |=> (cfg_err && !busy));

  // R8
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop && !start) |=> $stable(mod_out));

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> (pos < len));

endmodule

// File: tb/fsk_wavegen_bench.sv
module fsk_wavegen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MAXS = 1024;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, stop = 1'b0, tick = 1'b0, legacy = 1'b0, invert = 1'b0;
  logic [W-1:0] fc_high = '0, fc_low = '0, bit_clock = '0;
  logic bit_valid, bit_data, bit_last, bit_ready, mod_out, busy, cfg_err;

  logic frame [16];
  int   flen = 1;
  int   idx = 0;
  logic src_en = 1'b0;
  logic tick_en = 1'b0;
  int   tcnt = 0;
  logic cap [MAXS];
  logic expv [MAXS];
  int   ncap = 0;
  int   checks = 0, errors = 0;

  assign bit_valid = src_en;
  assign bit_data  = frame[idx];
  assign bit_last  = (idx == flen - 1);

  fsk_wavegen #(.W(W), .CW(16)) u_fsk_wavegen (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
    .legacy(legacy), .invert(invert), .fc_high(fc_high), .fc_low(fc_low),
    .bit_clock(bit_clock), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_last(bit_last), .bit_ready(bit_ready), .mod_out(mod_out),
    .busy(busy), .cfg_err(cfg_err));

  always @(posedge clk)
    if (!src_en) idx <= 0;
    else if (bit_valid && bit_ready) idx <= (idx == flen - 1) ? 0 : idx + 1;

  always @(negedge clk) begin
    if (tick) begin
      if (ncap < MAXS) cap[ncap] = mod_out;
      ncap = ncap + 1;
    end
    if (tick_en) tcnt = (tcnt + 1) % 4; else tcnt = 0;
    tick = tick_en && (tcnt == 3);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int en;
  task automatic push_wave(input int L, input bit ones_first, input int ns);
    for (int p = 0; p < L; p++) begin
      if (en < ns) expv[en] = ones_first ? (p < L/2) : (p >= L - L/2);
      en++;
    end
  endtask

  task automatic build_exp(input int fh, input int fl, input int ck, input bit inv,
                           input bit lg, input int ns);
    int bi, cnt, fc, nw, md;
    bit sel_lo;
    en = 0; bi = 0; cnt = 0;
    while (en < ns) begin
      if (bi == 0) cnt = 0;
      sel_lo = (frame[bi] == inv);
      if (lg) begin
        for (int w = 0; w < (sel_lo ? 6 : 5); w++) push_wave(sel_lo ? 8 : 10, 1'b1, ns);
      end else begin
        fc = sel_lo ? fl : fh;
        nw = ck / fc; md = ck % fc;
        for (int w = 0; w < nw; w++) push_wave(fc, 1'b0, ns);
        if (md != 0) begin
          cnt = (cnt + 1) % 65536;
          if (fc % md == 0) begin
            if (cnt % (fc / md) == 0) push_wave(fc, 1'b0, ns);
          end else push_wave(md, 1'b0, ns);
        end
      end
      bi = (bi + 1) % flen;
    end
  endtask

  task automatic set_frame(input logic [15:0] fv, input int n);
    flen = n;
    for (int i = 0; i < 16; i++) frame[i] = fv[i];
  endtask

  task automatic halt();
    @(negedge clk); tick_en = 1'b0; stop = 1'b1;
    @(negedge clk); stop = 1'b0; src_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_stream(input string req, input int fh, input int fl, input int ck,
                            input bit inv, input bit lg, input logic [15:0] fv, input int n,
                            input int ns, input bit scramble);
    int bad_at;
    set_frame(fv, n);
    fc_high = W'(fh); fc_low = W'(fl); bit_clock = W'(ck); invert = inv; legacy = lg;
    ncap = 0;
    @(negedge clk); src_en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (scramble) begin
      fc_high = W'(3); fc_low = W'(9); bit_clock = W'(17); invert = ~inv; legacy = ~lg;
    end
    @(negedge clk); tick_en = 1'b1;
    while (ncap < ns) @(negedge clk);
    tick_en = 1'b0;
    build_exp(fh, fl, ck, inv, lg, ns);
    bad_at = -1;
    for (int i = 0; i < ns; i++) if (bad_at < 0 && cap[i] !== expv[i]) bad_at = i;
    checks++;
    if (bad_at >= 0) begin
      errors++;
      $display("FAIL %s sample %0d: actual %0d expected %0d", req, bad_at, cap[bad_at], expv[bad_at]);
    end
    halt();
    fc_high = W'(fh); fc_low = W'(fl); bit_clock = W'(ck); invert = inv; legacy = lg;
  endtask

  task automatic t_reset();
    check("R12", "mod_out", mod_out, 0);
    check("R12", "busy", busy, 0);
    check("R12", "cfg_err", cfg_err, 0);
    check("R12", "bit_ready", bit_ready, 0);
  endtask

  // R1 R2 R3 R8: whole multiples, odd period 5
  task automatic t_basic();
    run_stream("R2_R3_R8", 5, 4, 40, 1'b0, 1'b0, 16'b1101, 4, 320, 1'b0);
  endtask

  task automatic t_invert();
    run_stream("R1", 5, 4, 40, 1'b1, 1'b0, 16'b1101, 4, 320, 1'b0);
  endtask

  // R4: remainder 2 divides 8, extra wave on every 4th counted bit
  task automatic t_extra();
    run_stream("R4", 10, 8, 50, 1'b0, 1'b0, 16'b01000100, 8, 800, 1'b0);
  endtask

  // R6: 3-bit frame never reaches count 4
  task automatic t_clear();
    run_stream("R6", 10, 8, 50, 1'b0, 1'b0, 16'b000, 3, 450, 1'b0);
  endtask

  // R5 R11: partial tail for period 7, extra wave for period 6, inputs changed mid-run
  task automatic t_partial();
    run_stream("R5_R11", 6, 7, 32, 1'b0, 1'b0, 16'b0110, 4, 400, 1'b1);
  endtask

  // R3 R4: clock shorter than period, bits with no samples
  task automatic t_short();
    run_stream("R3_R4", 2, 8, 4, 1'b0, 1'b0, 16'b100, 3, 120, 1'b0);
  endtask

  task automatic t_legacy();
    run_stream("R7", 0, 0, 0, 1'b0, 1'b1, 16'b0110, 4, 392, 1'b0);
  endtask

  task automatic t_error();
    fc_high = W'(6); fc_low = W'(1); bit_clock = W'(40); legacy = 1'b0; set_frame(16'b1, 1);
    ncap = 0;
    @(negedge clk); src_en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10", "cfg_err", cfg_err, 1);
    check("R10", "busy", busy, 0);
    tick_en = 1'b1;
    repeat (20) @(negedge clk);
    check("R10", "mod_out", mod_out, 0);
    tick_en = 1'b0; src_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stop();
    fc_high = W'(5); fc_low = W'(4); bit_clock = W'(40); invert = 1'b0; legacy = 1'b0;
    set_frame(16'b1, 1);
    @(negedge clk); src_en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10", "cfg_err cleared", cfg_err, 0);
    tick_en = 1'b1;
    while (mod_out !== 1'b1) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0; tick_en = 1'b0;
    check("R9", "mod_out", mod_out, 0);
    check("R9", "busy", busy, 0);
    src_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_invert();
    t_extra();
    t_clear();
    t_partial();
    t_short();
    t_legacy();
    t_error();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule